// File: doc/BRIEF.md
# RSSI-Triggered Receive Gain Controller

This block sets the receive gain of a radio front end, one packet at a time. While the receiver waits for traffic, it holds the coarse and fine gain codes at a programmable idle setting close to the top of the range, so that a faint packet from a distant node can still be heard. It also watches the digitized RSSI stream. When RSSI stays strictly above a programmable threshold for a programmable number of consecutive strobed samples, the block raises a one-cycle detect pulse. This energy test still works when a strong packet drives the analog chain into saturation.

After the detect pulse, the block runs a settling sequence of fixed length, clamped to between 36 and 48 samples. The first half chooses the coarse gain from the peak RSSI it sees. The second half moves the fine gain one step per sample toward a target level. The block then freezes both codes and raises a gain-locked level. The gain stays frozen until the downstream receiver pulses end of packet, or until a programmable sample timeout expires. On either event the idle gains come back on the next cycle.

Top module: `rx_gain_ctrl`

## Requirements
- R1: The detect pulse goes high for exactly one cycle, on the cycle after the clock edge that takes the Nth consecutive strobed RSSI sample strictly above `cfg_thresh`. N is `cfg_run_len`, and a value of 0 counts as 1.
- R2: A strobed sample equal to or below the threshold restarts the consecutive count. Cycles without a strobe neither add to the count nor break it.
- R3: While the block is neither settling nor locked, the gain outputs follow `cfg_idle_coarse` and `cfg_idle_fine` with one cycle of delay. During reset both codes read all ones, and the detect pulse and gain-locked flag read 0.
- R4: The settling length L is `cfg_settle_len` clamped to the range [36, 48]. The gain-locked flag rises on the cycle after the Lth strobed sample that follows the detecting sample.
- R5: The first floor(L/2) settling samples form the coarse window. At the end of that window the coarse code becomes the bitwise inverse of the top 2 bits of the largest RSSI seen in the window.
- R6: On each of the remaining L - floor(L/2) samples, the fine code steps down by 1 if RSSI > `cfg_target` and up by 1 if RSSI < `cfg_target`. It saturates at 0 and at all ones, and holds when RSSI equals the target.
- R7: While gain-locked stays high, neither gain code changes.
- R8: An end-of-packet pulse while locked clears gain-locked and restores the idle codes on the next cycle. An end-of-packet pulse during settling is ignored, and lock still arrives after L samples.
- R9: After `cfg_timeout` strobed samples in the locked state with no end-of-packet pulse (a value of 0 counts as 1), the block drops the lock and restores the idle codes.
- R10: No detect pulse occurs while the block is settling or locked, whatever the RSSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | RSSI sample strobe |
| rssi | input | RSSI_W | Digitized RSSI, unsigned |
| pkt_end | input | 1 | End-of-packet pulse from the receiver |
| cfg_thresh | input | RSSI_W | Detection threshold |
| cfg_target | input | RSSI_W | Fine-gain target level |
| cfg_run_len | input | RUN_W | Consecutive samples needed for detection |
| cfg_settle_len | input | CNT_W | Requested settling length, in samples |
| cfg_timeout | input | TO_W | Lock timeout, in samples |
| cfg_idle_coarse | input | CG_W | Idle coarse gain code |
| cfg_idle_fine | input | FG_W | Idle fine gain code |
| gain_coarse | output | CG_W | Coarse gain code to the transceiver |
| gain_fine | output | FG_W | Fine gain code to the transceiver |
| det_pulse | output | 1 | One-cycle coarse packet detect |
| gain_locked | output | 1 | Gain frozen for the current packet |

## Verification
A wrong run counter moves the detect pulse by one or more samples, and the bench sees that on the cycle after the expected detecting edge. A wrong settle counter or a wrong window split moves the rise of gain-locked away from sample L, or changes the fine code, because the fine code records the number of samples in the fine window. A wrong peak register shows up in the coarse code at the moment of lock. A stuck state shows up as a lock that survives the end-of-packet pulse or the timeout, visible one cycle later.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COARSE = 2'd1,
      ST_FINE   = 2'd2,
      ST_LOCK   = 2'd3
   } rxg_state_e;
endpackage

// File: rtl/rxg_run_detect.sv
module rxg_run_detect #(
   parameter int RSSI_W = 10,
   parameter int RUN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp_vld,
   input  logic [RSSI_W-1:0] rssi,
   input  logic [RSSI_W-1:0] thresh,
   input  logic [RUN_W-1:0]  run_len,
   output logic              hit
);
   logic [RUN_W-1:0] run_cnt;
   logic [RUN_W:0]   need;
   logic [RUN_W:0]   seen;
   logic             above;

   assign above = rssi > thresh;
   assign need  = (run_len == '0) ? (RUN_W+1)'(1) : {1'b0, run_len};
   assign seen  = {1'b0, run_cnt} + (RUN_W+1)'(1);
   assign hit   = smp_vld && above && (seen >= need);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         run_cnt <= '0;
      end else if (smp_vld) begin
         if (!above)
            run_cnt <= '0;
         else if (run_cnt != '1)
            run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rxg_budget.sv
module rxg_budget #(
   parameter int CNT_W      = 6,
   parameter int SETTLE_MIN = 36,
   parameter int SETTLE_MAX = 48
) (
   input  logic [CNT_W-1:0] req_len,
   output logic [CNT_W-1:0] n_coarse,
   output logic [CNT_W-1:0] n_fine
);
   localparam logic [CNT_W-1:0] LO = CNT_W'(SETTLE_MIN);
   localparam logic [CNT_W-1:0] HI = CNT_W'(SETTLE_MAX);

   logic [CNT_W-1:0] eff;

   always_comb begin
      if (req_len < LO)      eff = LO;
      else if (req_len > HI) eff = HI;
      else                   eff = req_len;
      n_coarse = eff >> 1;
      n_fine   = eff - n_coarse;
   end
endmodule

// File: rtl/rxg_fine_step.sv
module rxg_fine_step #(
   parameter int RSSI_W = 10,
   parameter int FG_W   = 6
) (
   input  logic [FG_W-1:0]   cur,
   input  logic [RSSI_W-1:0] rssi,
   input  logic [RSSI_W-1:0] target,
   output logic [FG_W-1:0]   nxt
);
   always_comb begin
      nxt = cur;
      if (rssi > target) begin
         if (cur != '0) nxt = cur - 1'b1;
      end else if (rssi < target) begin
         if (cur != '1) nxt = cur + 1'b1;
      end
   end
endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
   import rxg_pkg::*;
#(
   parameter int RSSI_W     = 10,
   parameter int CG_W       = 2,
   parameter int FG_W       = 6,
   parameter int RUN_W      = 4,
   parameter int CNT_W      = 6,
   parameter int TO_W       = 12,
   parameter int SETTLE_MIN = 36,
   parameter int SETTLE_MAX = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [RSSI_W-1:0] rssi,
   input  logic              pkt_end,
   input  logic [RSSI_W-1:0] cfg_thresh,
   input  logic [RSSI_W-1:0] cfg_target,
   input  logic [RUN_W-1:0]  cfg_run_len,
   input  logic [CNT_W-1:0]  cfg_settle_len,
   input  logic [TO_W-1:0]   cfg_timeout,
   input  logic [CG_W-1:0]   cfg_idle_coarse,
   input  logic [FG_W-1:0]   cfg_idle_fine,
   output logic [CG_W-1:0]   gain_coarse,
   output logic [FG_W-1:0]   gain_fine,
   output logic              det_pulse,
   output logic              gain_locked
);
   localparam logic [TO_W-1:0] TO_ONE = TO_W'(1);

   initial begin
      if (SETTLE_MIN < 2 || SETTLE_MIN > SETTLE_MAX)
         $error("rx_gain_ctrl: settle range is empty");
      if ((1 << CNT_W) <= SETTLE_MAX)
         $error("rx_gain_ctrl: CNT_W too narrow for SETTLE_MAX");
      if (CG_W > RSSI_W)
         $error("rx_gain_ctrl: CG_W wider than RSSI_W");
   end

   rxg_state_e        state;
   logic [CNT_W-1:0]  settle_cnt;
   logic [TO_W-1:0]   hold_cnt;
   logic [RSSI_W-1:0] peak;
   logic [RSSI_W-1:0] peak_nxt;
   logic [CG_W-1:0]   g_c;
   logic [FG_W-1:0]   g_f;
   logic [FG_W-1:0]   g_f_nxt;
   logic              det_q;
   logic              hit;
   logic [CNT_W-1:0]  n_coarse;
   logic [CNT_W-1:0]  n_fine;
   logic [TO_W-1:0]   to_last;

   rxg_run_detect #(.RSSI_W(RSSI_W), .RUN_W(RUN_W)) i_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state != ST_IDLE),
      .smp_vld (smp_vld),
      .rssi    (rssi),
      .thresh  (cfg_thresh),
      .run_len (cfg_run_len),
      .hit     (hit)
   );

   rxg_budget #(.CNT_W(CNT_W), .SETTLE_MIN(SETTLE_MIN), .SETTLE_MAX(SETTLE_MAX)) i_budget (
      .req_len  (cfg_settle_len),
      .n_coarse (n_coarse),
      .n_fine   (n_fine)
   );

   rxg_fine_step #(.RSSI_W(RSSI_W), .FG_W(FG_W)) i_step (
      .cur    (g_f),
      .rssi   (rssi),
      .target (cfg_target),
      .nxt    (g_f_nxt)
   );

   assign peak_nxt = (rssi > peak) ? rssi : peak;
   assign to_last  = ((cfg_timeout == '0) ? TO_ONE : cfg_timeout) - TO_ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         settle_cnt <= '0;
         hold_cnt   <= '0;
         peak       <= '0;
         g_c        <= '1;
         g_f        <= '1;
         det_q      <= 1'b0;
      end else begin
         det_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               g_c        <= cfg_idle_coarse;
               g_f        <= cfg_idle_fine;
               settle_cnt <= '0;
               hold_cnt   <= '0;
               peak       <= '0;
               if (hit) begin
                  det_q <= 1'b1;
                  state <= ST_COARSE;
               end
            end
            ST_COARSE: begin
               if (smp_vld) begin
                  peak <= peak_nxt;
                  if (settle_cnt == n_coarse - 1'b1) begin
                     g_c        <= ~peak_nxt[RSSI_W-1 -: CG_W];
                     settle_cnt <= '0;
                     state      <= ST_FINE;
                  end else begin
                     settle_cnt <= settle_cnt + 1'b1;
                  end
               end
            end
            ST_FINE: begin
               if (smp_vld) begin
                  g_f <= g_f_nxt;
                  if (settle_cnt == n_fine - 1'b1) begin
                     settle_cnt <= '0;
                     state      <= ST_LOCK;
                  end else begin
                     settle_cnt <= settle_cnt + 1'b1;
                  end
               end
            end
            ST_LOCK: begin
               if (pkt_end || (smp_vld && hold_cnt == to_last)) begin
                  g_c   <= cfg_idle_coarse;
                  g_f   <= cfg_idle_fine;
                  state <= ST_IDLE;
               end else if (smp_vld) begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign gain_coarse = g_c;
   assign gain_fine   = g_f;
   assign det_pulse   = det_q;
   assign gain_locked = (state == ST_LOCK);
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk #(
   parameter int CG_W = 2,
   parameter int FG_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pkt_end,
   input logic [CG_W-1:0] cfg_idle_coarse,
   input logic [FG_W-1:0] cfg_idle_fine,
   input logic [CG_W-1:0] gain_coarse,
   input logic [FG_W-1:0] gain_fine,
   input logic            det_pulse,
   input logic            gain_locked
);
   // R1
   det_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_pulse |=> !det_pulse);

   // R10
   det_not_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gain_locked |-> !det_pulse);

   // R7
   lock_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_locked && $past(gain_locked)) |-> ($stable(gain_coarse) && $stable(gain_fine)));

   // R8
   end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_locked && pkt_end) |=> (!gain_locked
         && gain_coarse == $past(cfg_idle_coarse) && gain_fine == $past(cfg_idle_fine)));

   // R3
   det_idle_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_pulse |-> (gain_coarse == $past(cfg_idle_coarse) && gain_fine == $past(cfg_idle_fine)));

   // R4
   lock_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gain_locked) |-> !$past(det_pulse));
endmodule

bind rx_gain_ctrl rxg_chk #(.CG_W(CG_W), .FG_W(FG_W)) i_rxg_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .pkt_end         (pkt_end),
   .cfg_idle_coarse (cfg_idle_coarse),
   .cfg_idle_fine   (cfg_idle_fine),
   .gain_coarse     (gain_coarse),
   .gain_fine       (gain_fine),
   .det_pulse       (det_pulse),
   .gain_locked     (gain_locked)
);

// File: tb/test_rx_gain_ctrl.sv
module test_rx_gain_ctrl;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [9:0]  rssi = '0;
   logic        pkt_end = 1'b0;
   logic [9:0]  cfg_thresh = 10'd300;
   logic [9:0]  cfg_target = 10'd400;
   logic [3:0]  cfg_run_len = 4'd3;
   logic [5:0]  cfg_settle_len = 6'd40;
   logic [11:0] cfg_timeout = 12'd1000;
   logic [1:0]  cfg_idle_coarse = 2'd3;
   logic [5:0]  cfg_idle_fine = 6'd50;
   logic [1:0]  gain_coarse;
   logic [5:0]  gain_fine;
   logic        det_pulse;
   logic        gain_locked;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rx_gain_ctrl i_rx_gain_ctrl (
      .clk, .rst_n, .smp_vld, .rssi, .pkt_end,
      .cfg_thresh, .cfg_target, .cfg_run_len, .cfg_settle_len, .cfg_timeout,
      .cfg_idle_coarse, .cfg_idle_fine,
      .gain_coarse, .gain_fine, .det_pulse, .gain_locked
   );

   typedef struct packed {
      logic [9:0] lvl;
      logic [5:0] settle;
      logic [3:0] run;
      logic [5:0] eff;
      logic [1:0] ec;
      logic [5:0] ef;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{lvl: 10'd500,  settle: 6'd40, run: 4'd3, eff: 6'd40, ec: 2'd2, ef: 6'd30},
      '{lvl: 10'd350,  settle: 6'd30, run: 4'd1, eff: 6'd36, ec: 2'd2, ef: 6'd63},
      '{lvl: 10'd1000, settle: 6'd60, run: 4'd0, eff: 6'd48, ec: 2'd0, ef: 6'd26},
      '{lvl: 10'd400,  settle: 6'd45, run: 4'd5, eff: 6'd45, ec: 2'd2, ef: 6'd50},
      '{lvl: 10'd800,  settle: 6'd36, run: 4'd2, eff: 6'd36, ec: 2'd0, ef: 6'd32}
   };

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic smp(input logic [9:0] v);
      rssi = v;
      smp_vld = 1'b1;
      @(posedge clk);
      #1;
      smp_vld = 1'b0;
   endtask

   task automatic gap(input int n);
      smp_vld = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic end_pkt();
      pkt_end = 1'b1;
      @(posedge clk);
      #1;
      pkt_end = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int need;
      int seen;
      // reset state (R3)
      repeat (3) @(posedge clk);
      #1;
      check("R3 reset det", det_pulse, 0);
      check("R3 reset lock", gain_locked, 0);
      check("R3 reset coarse", gain_coarse, 3);
      check("R3 reset fine", gain_fine, 63);
      rst_n = 1'b1;
      gap(2);
      check("R3 idle fine", gain_fine, 50);
      cfg_idle_fine = 6'd20;
      gap(1);
      check("R3 idle follow", gain_fine, 20);
      cfg_idle_fine = 6'd50;
      gap(1);

      // table of packets: R1 R4 R5 R6 R7 R8 R10
      for (int k = 0; k < 5; k++) begin
         cfg_run_len    = VECS[k].run;
         cfg_settle_len = VECS[k].settle;
         need = (VECS[k].run == 0) ? 1 : int'(VECS[k].run);
         seen = 0;
         for (int i = 0; i < need - 1; i++) begin
            smp(VECS[k].lvl);
            seen += det_pulse;
         end
         check("R1 early det", seen, 0);
         smp(VECS[k].lvl);
         check("R1 det on run", det_pulse, 1);
         smp(VECS[k].lvl);
         check("R1 det width", det_pulse, 0);
         for (int i = 1; i < VECS[k].eff - 1; i++) smp(VECS[k].lvl);
         check("R4 not yet locked", gain_locked, 0);
         smp(VECS[k].lvl);
         check("R4 locked at L", gain_locked, 1);
         check("R5 coarse", gain_coarse, VECS[k].ec);
         check("R6 fine", gain_fine, VECS[k].ef);
         seen = 0;
         for (int i = 0; i < 6; i++) begin
            smp(10'd1023 - VECS[k].lvl / 2);
            seen += det_pulse;
         end
         check("R10 no det locked", seen, 0);
         check("R7 coarse frozen", gain_coarse, VECS[k].ec);
         check("R7 fine frozen", gain_fine, VECS[k].ef);
         rssi = '0;
         end_pkt();
         check("R8 unlock", gain_locked, 0);
         check("R8 idle coarse", gain_coarse, 3);
         check("R8 idle fine", gain_fine, 50);
         gap(3);
      end

      // spikes and threshold-equal samples never detect (R2)
      cfg_run_len = 4'd3;
      cfg_settle_len = 6'd40;
      seen = 0;
      smp(10'd500); seen += det_pulse;
      smp(10'd500); seen += det_pulse;
      smp(10'd100); seen += det_pulse;
      smp(10'd500); seen += det_pulse;
      smp(10'd500); seen += det_pulse;
      smp(10'd300); seen += det_pulse;
      smp(10'd500); seen += det_pulse;
      smp(10'd500); seen += det_pulse;
      smp(10'd0);   seen += det_pulse;
      check("R2 broken runs", seen, 0);
      // gaps without strobe keep the run (R2)
      smp(10'd500); gap(2);
      smp(10'd500); gap(2);
      check("R2 not yet", det_pulse, 0);
      smp(10'd500);
      check("R2 det across gaps", det_pulse, 1);

      // end of packet during settling is ignored (R8)
      for (int i = 1; i < 40; i++) begin
         if (i == 10) pkt_end = 1'b1;
         smp(10'd0);
         pkt_end = 1'b0;
      end
      check("R8 ignored in settle", gain_locked, 0);
      smp(10'd0);
      check("R8 lock after ignore", gain_locked, 1);
      check("R5 coarse low rssi", gain_coarse, 3);
      check("R6 fine saturates", gain_fine, 63);

      // timeout with strobe gaps (R9)
      cfg_timeout = 12'd10;
      for (int i = 0; i < 9; i++) begin
         smp(10'd0);
         gap(1);
      end
      check("R9 held before timeout", gain_locked, 1);
      smp(10'd0);
      check("R9 timeout unlock", gain_locked, 0);
      check("R9 idle fine", gain_fine, 50);
      gap(2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule